// File: doc/BRIEF.md
# IEC958 Channel-Status Capture Buffer

This block gathers the 192-bit channel-status block that an IEC958 (S/PDIF) stream carries at one bit per frame, and presents it to a host as 32-bit words. It sits after the line decoder, which already delivers the decoded fields of each subframe. Those fields are a one-cycle strobe, a flag naming the subframe as channel A or B, the channel-status bit, and a marker for the frame that opens a new status block. The bus wrapper around the block is not part of it.

A control input names the channel whose status is collected. Bits from that channel are shifted in from the block-start frame onward. When the 192nd bit arrives, the whole block is copied into a held image in one step. A 3-bit word select picks one 32-bit slice of the held image for the read-data output. A read therefore never shows part of one block mixed with part of another.

Top module: `chsts_capture`

## Requirements
- R1: A synchronous active-high reset clears the collection state and the held image, so every select value reads zero afterwards.
- R2: An accepted subframe that carries no block-start marker is ignored while no block is in progress. A block is not in progress after reset or after a block completes.
- R3: A subframe is accepted only when the strobe is high and its flag (0 = channel A, 1 = channel B) equals the channel control (0 = A, 1 = B). Subframes of the other channel have no effect, including their block-start markers.
- R4: The n-th status bit of a block (n = 0 for the block-start frame, up to 191) is stored in status byte n/8 at bit position n mod 8, so the earliest bit is the least significant.
- R5: Word select s (0 to 5) returns status bytes 4s to 4s+3, with byte 4s+j in bits [8j+7:8j] of the read data.
- R6: Word select values 6 and 7 return zero.
- R7: The held image changes only at the clock edge that accepts bit 191 of a block. It shows the new block from the next cycle on. Until then it shows the previous complete block.
- R8: An accepted block-start marker while a block is in progress discards the partial block and restarts collection at bit 0 with the marker frame's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sub_vld | input | 1 | One-cycle strobe per decoded subframe |
| sub_is_b | input | 1 | Subframe channel flag: 0 = A, 1 = B |
| cs_bit | input | 1 | Channel-status bit of the subframe |
| blk_start | input | 1 | Subframe belongs to the first frame of a status block |
| chan_sel_b | input | 1 | Channel to capture: 0 = A, 1 = B |
| word_sel | input | 3 | Select of the 32-bit word shown on rd_data |
| rd_data | output | 32 | Selected word of the held status block |

## Verification
Completion of a block and a host read of the word that completion rewrites can fall in the same cycle. The bench provokes this by holding the select at the last word and presenting bit 191 of a new block. It samples the read data while that bit is on the inputs, where the previous block is expected, and again one cycle later, where the new block is expected. A restart marker in the middle of a block and a foreign-channel marker in the middle of a block are also placed against a held image that is already valid. This shows that neither one disturbs what the host reads.

// File: rtl/chsts_pkg.sv
package chsts_pkg;
    localparam int unsigned CS_BLOCK_BITS = 192;
    localparam int unsigned CS_WORD_W     = 32;
    localparam int unsigned CS_SEL_W      = 3;

    // one accepted subframe of the captured channel
    typedef struct packed {
        logic take;
        logic first;
        logic bit_v;
    } cs_evt_t;
endpackage

// File: rtl/chsts_accept.sv
module chsts_accept
    import chsts_pkg::*;
(
    input  logic    sub_vld,
    input  logic    sub_is_b,
    input  logic    cs_bit,
    input  logic    blk_start,
    input  logic    chan_sel_b,
    output cs_evt_t evt
);
    always_comb begin
        evt.take  = sub_vld && (sub_is_b == chan_sel_b);
        evt.first = blk_start;
        evt.bit_v = cs_bit;
    end
endmodule

// File: rtl/chsts_collect.sv
module chsts_collect
    import chsts_pkg::*;
#(
    parameter int unsigned BLOCK_BITS = CS_BLOCK_BITS,
    localparam int unsigned CNT_W     = $clog2(BLOCK_BITS)
)(
    input  logic                  clk,
    input  logic                  rst,
    input  cs_evt_t               evt,
    output logic [BLOCK_BITS-1:0] held,
    output logic [CNT_W-1:0]      idx,
    output logic                  commit
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLOCK_BITS - 1);

    typedef struct packed {
        logic [BLOCK_BITS-1:0] shift;
        logic [BLOCK_BITS-1:0] held;
        logic [CNT_W-1:0]      idx;    // 0 = idle, else next bit number
    } col_st_t;

    col_st_t st_d, st_q;
    logic    commit_d;

    always_comb begin
        st_d     = st_q;
        commit_d = 1'b0;
        if (evt.take) begin
            if (evt.first) begin
                st_d.shift = {evt.bit_v, st_q.shift[BLOCK_BITS-1:1]};
                st_d.idx   = CNT_W'(1);
            end else if (st_q.idx != '0) begin
                st_d.shift = {evt.bit_v, st_q.shift[BLOCK_BITS-1:1]};
                if (st_q.idx == LAST_IDX) begin
                    st_d.held = st_d.shift;
                    st_d.idx  = '0;
                    commit_d  = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign held   = st_q.held;
    assign idx    = st_q.idx;
    assign commit = commit_d;
endmodule

// File: rtl/chsts_window.sv
module chsts_window
    import chsts_pkg::*;
#(
    parameter int unsigned BLOCK_BITS = CS_BLOCK_BITS,
    parameter int unsigned WORD_W     = CS_WORD_W,
    parameter int unsigned SEL_W      = CS_SEL_W,
    localparam int unsigned NUM_WORDS = BLOCK_BITS / WORD_W,
    localparam int unsigned NUM_SEL   = 1 << SEL_W
)(
    input  logic [BLOCK_BITS-1:0] held,
    input  logic [SEL_W-1:0]      word_sel,
    output logic [WORD_W-1:0]     rd_data
);
    logic [WORD_W-1:0] slot [NUM_SEL];

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_slot
        if (g < NUM_WORDS) begin : g_live
            assign slot[g] = held[g*WORD_W +: WORD_W];
        end else begin : g_zero
            assign slot[g] = '0;
        end
    end

    assign rd_data = slot[word_sel];
endmodule

// File: rtl/chsts_capture.sv
module chsts_capture
    import chsts_pkg::*;
#(
    parameter int unsigned BLOCK_BITS = CS_BLOCK_BITS,
    parameter int unsigned WORD_W     = CS_WORD_W,
    parameter int unsigned SEL_W      = CS_SEL_W,
    localparam int unsigned CNT_W     = $clog2(BLOCK_BITS)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              sub_vld,
    input  logic              sub_is_b,
    input  logic              cs_bit,
    input  logic              blk_start,
    input  logic              chan_sel_b,
    input  logic [SEL_W-1:0]  word_sel,
    output logic [WORD_W-1:0] rd_data
);
    cs_evt_t               evt;
    logic [BLOCK_BITS-1:0] held;
    logic [CNT_W-1:0]      idx_q;
    logic                  commit;

    chsts_accept u_accept (
        .sub_vld(sub_vld), .sub_is_b(sub_is_b), .cs_bit(cs_bit),
        .blk_start(blk_start), .chan_sel_b(chan_sel_b), .evt(evt)
    );

    chsts_collect #(.BLOCK_BITS(BLOCK_BITS)) u_collect (
        .clk(clk), .rst(rst), .evt(evt),
        .held(held), .idx(idx_q), .commit(commit)
    );

    chsts_window #(.BLOCK_BITS(BLOCK_BITS), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_window (
        .held(held), .word_sel(word_sel), .rd_data(rd_data)
    );
endmodule

// File: rtl/chsts_capture_chk.sv
module chsts_capture_chk #(
    parameter int unsigned BLOCK_BITS = 192,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned SEL_W      = 3,
    parameter int unsigned CNT_W      = 8
)(
    input logic              clk,
    input logic              rst,
    input logic              sub_vld,
    input logic              sub_is_b,
    input logic              blk_start,
    input logic              chan_sel_b,
    input logic [SEL_W-1:0]  word_sel,
    input logic [WORD_W-1:0] rd_data,
    input logic [CNT_W-1:0]  idx_q,
    input logic              commit
);
    localparam int unsigned NUM_WORDS = BLOCK_BITS / WORD_W;

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> (idx_q == '0) && (rd_data == '0));

    a_r2_index_bound: assert property (@(posedge clk) disable iff (rst)
        int'(idx_q) < BLOCK_BITS);

    a_r3_foreign_no_effect: assert property (@(posedge clk) disable iff (rst)
        (sub_vld && (sub_is_b != chan_sel_b)) |=> $stable(idx_q));

    a_r3_idle_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !sub_vld |=> $stable(idx_q));

    a_r6_high_select_zero: assert property (@(posedge clk) disable iff (rst)
        (int'(word_sel) >= NUM_WORDS) |-> (rd_data == '0));

    a_r7_hold_between_blocks: assert property (@(posedge clk) disable iff (rst)
        ($stable(word_sel) && !$past(commit)) |-> $stable(rd_data));

    a_r8_restart_at_one: assert property (@(posedge clk) disable iff (rst)
        (sub_vld && (sub_is_b == chan_sel_b) && blk_start) |=> (idx_q == CNT_W'(1)));
endmodule

bind chsts_capture chsts_capture_chk #(
    .BLOCK_BITS(BLOCK_BITS), .WORD_W(WORD_W), .SEL_W(SEL_W), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst(rst), .sub_vld(sub_vld), .sub_is_b(sub_is_b),
    .blk_start(blk_start), .chan_sel_b(chan_sel_b), .word_sel(word_sel),
    .rd_data(rd_data), .idx_q(idx_q), .commit(commit)
);

// File: tb/chsts_capture_tb.sv
`timescale 1ns/1ps
module chsts_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sub_vld = 1'b0, sub_is_b = 1'b0, cs_bit = 1'b0, blk_start = 1'b0;
    logic        chan_sel_b = 1'b0;
    logic [2:0]  word_sel = 3'd0;
    logic [31:0] rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    chsts_capture dut_i (
        .clk(clk), .rst(rst), .sub_vld(sub_vld), .sub_is_b(sub_is_b),
        .cs_bit(cs_bit), .blk_start(blk_start), .chan_sel_b(chan_sel_b),
        .word_sel(word_sel), .rd_data(rd_data)
    );

    function automatic logic pat(input int s, input int n);
        return logic'(((n * (2 * s + 1) + (n >> 3) * s + s * 5) >> 1) & 1);
    endfunction

    // R4/R5 layout: word w bit b = block bit 32w+b; selects 6,7 give zero (R6)
    function automatic logic [31:0] expw(input int s, input int w);
        logic [31:0] r = '0;
        if (s < 0 || w >= 6) return '0;
        for (int b = 0; b < 32; b++) r[b] = pat(s, 32 * w + b);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic send(input logic is_b, input logic b, input logic st);
        @(negedge clk);
        sub_vld = 1'b1; sub_is_b = is_b; cs_bit = b; blk_start = st;
        @(negedge clk);
        sub_vld = 1'b0; blk_start = 1'b0;
    endtask

    // bits from..to of block s on channel ch, foreign subframes interleaved
    task automatic send_range(input int s, input logic ch, input int from, input int to);
        for (int n = from; n <= to; n++) begin
            send(~ch, ~pat(s, n), (n == 0) || (n == 100));
            send(ch, pat(s, n), n == 0);
        end
    endtask

    task automatic check_all(input int s, input string tag);
        for (int w = 0; w < 8; w++) begin
            @(negedge clk);
            word_sel = 3'(w);
            #1;
            chk($sformatf("%s sel=%0d", tag, w), rd_data, expw(s, w));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check_all(-1, "R1 reset");

        // R2: non-start bits while idle are ignored
        for (int n = 0; n < 192; n++) send(1'b0, 1'b1, 1'b0);
        check_all(-1, "R2 idle from reset");

        // sweep seeds and both channels; R3 R4 R5 R6 R7
        for (int s = 1; s <= 4; s++) begin
            chan_sel_b = logic'(s & 1);
            send_range(s, chan_sel_b, 0, 191);
            check_all(s, $sformatf("R4 R5 R3 block s=%0d ch=%0d", s, chan_sel_b));

            // R2: after completion, unmarked bits ignored
            for (int n = 0; n < 192; n++) send(chan_sel_b, 1'b1, 1'b0);
            check_all(s, "R2 idle after block");

            // R8 and R7: partial block, then restart marker
            send_range(s + 10, chan_sel_b, 0, 120);
            check_all(s, "R7 partial keeps old");
            send_range(s + 20, chan_sel_b, 0, 190);
            check_all(s, "R7 R8 restarted not yet done");

            // R7: completion and read of same word in one cycle
            @(negedge clk);
            word_sel = 3'd5;
            sub_vld = 1'b1; sub_is_b = chan_sel_b; cs_bit = pat(s + 20, 191); blk_start = 1'b0;
            #1;
            chk("R7 same-cycle read old", rd_data, expw(s, 5));
            @(negedge clk);
            sub_vld = 1'b0;
            #1;
            chk("R7 next-cycle read new", rd_data, expw(s + 20, 5));
            check_all(s + 20, "R8 restarted block");
        end

        // R1: reset mid-block and with a held image
        send_range(7, chan_sel_b, 0, 50);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check_all(-1, "R1 reset clears");
        send_range(7, chan_sel_b, 51, 191);
        check_all(-1, "R1 R2 tail after reset ignored");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule